// File: doc/BRIEF.md
# Dual-Mode Hash Compression Step Datapath

This block is the arithmetic core of a hash engine that runs either of two 32-bit message-digest compressions, chosen by a mode input. Mode 0 is MD5; mode 1 is RIPEMD-160. On every accepted strobe it advances a five-word working state by one step. The step adds the current message word, the step constant and a round-dependent nonlinear function of three state words. It then rotates the sum left by a variable amount and moves the words into their new positions.

The block also keeps the 160-bit chaining value and applies the end-of-block feed-forward. RIPEMD-160 has two lines. Only one of them is built in logic, so the two run one after the other. An external sequencer runs the left line first and then issues a swap. The swap saves the left-line result in a private register and reloads the working state from the chaining value for the right line. A closing fold then merges the chaining value, the saved left result and the right result. Message words, constants, rotate amounts, round codes and the strobe order all come from the sequencer outside this block.

Top module: `hash_step_core`

## Requirements
- R1: When reset is low at a clock edge, or when `init_i` is high at a clock edge, the chaining value loads the initial value for the current `mode_i`. For A, B, C and D this is 67452301, efcdab89, 98badcfe and 10325476. E is c3d2e1f0 in mode 1 and 0 in mode 0. The working state takes the same value. Words sit in both 160-bit outputs as A at [159:128], B at [127:96], C at [95:64], D at [63:32] and E at [31:0].
- R2: In a cycle with no strobe (`init_i`, `step_i`, `swap_i` and `final_i` all low), the working state and the chaining value keep their values, whatever the data inputs do.
- R3: An MD5 step (mode 0) sets T = rotl(A + F + X + K, s). The new state is A'=D, B'=B+T, C'=B, D'=C, and E is unchanged. A step leaves the chaining value unchanged.
- R4: In mode 0, `round_i[1:0]` selects F. Round 0 uses (B&C)|(~B&D), round 1 uses (B&D)|(C&~D), round 2 uses B^C^D and round 3 uses C^(B|~D).
- R5: A RIPEMD-160 step (mode 1) sets T = rotl(A + F + X + K, s) + E. The new state is A'=E, B'=T, C'=B, D'=rotl(C,10) and E'=D. A step leaves the chaining value unchanged.
- R6: In mode 1, `round_i` values 0 to 4 select F. Code 0 is B^C^D, code 1 is (B&C)|(~B&D), code 2 is (B|~C)^D, code 3 is (B&D)|(C&~D) and code 4 is B^(C|~D). The right line is run by driving the codes in the order 4 down to 0.
- R7: In mode 0, all five bits of `rot_i` set the rotate amount (0 to 31). In mode 1, `rot_i[4]` is ignored and only `rot_i[3:0]` is used.
- R8: A swap strobe copies the working state into the saved-left register and reloads the working state from the chaining value. The chaining value does not change.
- R9: A final strobe in mode 0 adds working words A to D into chaining words A to D, each modulo 2^32. Chaining word E is unchanged, and the working state takes the new chaining value.
- R10: A final strobe in mode 1 sets the new chaining word i to chain[(i+1) mod 5] + saved[(i+2) mod 5] + work[(i+3) mod 5], where index 0 is A and 4 is E. The working state takes the new chaining value.
- R11: When several strobes arrive together, `init_i` takes priority over `final_i`, `final_i` over `swap_i`, and `swap_i` over `step_i`. Only the highest one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads the initial value for `mode_i` |
| mode_i | input | 1 | 0 = MD5, 1 = RIPEMD-160 |
| init_i | input | 1 | Load the initial chaining value |
| step_i | input | 1 | Perform one compression step |
| swap_i | input | 1 | Save the left line and reload from the chaining value |
| final_i | input | 1 | End-of-block feed-forward |
| round_i | input | 3 | Round code that selects the nonlinear function |
| msg_i | input | 32 | Message word X for this step |
| const_i | input | 32 | Step constant K |
| rot_i | input | 5 | Left-rotate amount s |
| state_o | output | 160 | Working state A..E |
| chain_o | output | 160 | Chaining value A..E |

## Verification
The assertions check on every cycle that the state holds when there is no strobe, that the chaining value holds during steps, and that the words land in the right positions after each step. That includes the fixed 10-bit rotate of C in RIPEMD mode. They also check that a swap reloads the working state from the chaining value, and that init wins over simultaneous strobes. The new B word, the choice of nonlinear function for each round, the ignored fifth rotate bit and both feed-forward folds depend on full 32-bit arithmetic. Only the bench can show these: it sweeps every round code with every rotate amount in both modes and compares against its own arithmetic model.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 5;
  localparam int ROT_W     = $clog2(WORD_W);
  localparam int FIXED_ROT = 10;
  localparam int ROUND_W   = 3;
  localparam int NUM_FN    = 6;
  localparam int STATE_W   = WORD_W * NUM_WORDS;

  // word slots inside a packed vector: A in the top slot
  localparam int SLOT_A = 4;
  localparam int SLOT_B = 3;
  localparam int SLOT_C = 2;
  localparam int SLOT_D = 1;
  localparam int SLOT_E = 0;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] vec_t;

  typedef enum logic [2:0] {
    FN_PARITY = 3'd0,  // x ^ y ^ z
    FN_CHOOSE = 3'd1,  // x picks y or z
    FN_ZSEL   = 3'd2,  // z picks x or y
    FN_YORNZ  = 3'd3,  // y ^ (x | ~z)
    FN_ORNY_Z = 3'd4,  // (x | ~y) ^ z
    FN_XORNZ  = 3'd5   // x ^ (y | ~z)
  } fn_e;

  function automatic word_t rotl(word_t x, int unsigned amt);
    int unsigned a;
    a = amt % WORD_W;
    if (a == 0) return x;
    return (x << a) | (x >> (WORD_W - a));
  endfunction

  function automatic word_t nl_eval(fn_e fn, word_t x, word_t y, word_t z);
    case (fn)
      FN_PARITY: return x ^ y ^ z;
      FN_CHOOSE: return (x & y) | (~x & z);
      FN_ZSEL:   return (x & z) | (y & ~z);
      FN_YORNZ:  return y ^ (x | ~z);
      FN_ORNY_Z: return (x | ~y) ^ z;
      default:   return x ^ (y | ~z);
    endcase
  endfunction

  function automatic fn_e fn_pick(logic rmd, logic [ROUND_W-1:0] rnd);
    if (!rmd) begin
      case (rnd[1:0])
        2'd0:    return FN_CHOOSE;
        2'd1:    return FN_ZSEL;
        2'd2:    return FN_PARITY;
        default: return FN_YORNZ;
      endcase
    end
    case (rnd)
      3'd0:    return FN_PARITY;
      3'd1:    return FN_CHOOSE;
      3'd2:    return FN_ORNY_Z;
      3'd3:    return FN_ZSEL;
      3'd4:    return FN_XORNZ;
      default: return FN_PARITY;
    endcase
  endfunction

  function automatic word_t iv_word(logic rmd, int unsigned slot);
    case (slot)
      SLOT_A:  return 32'h67452301;
      SLOT_B:  return 32'hefcdab89;
      SLOT_C:  return 32'h98badcfe;
      SLOT_D:  return 32'h10325476;
      default: return rmd ? 32'hc3d2e1f0 : 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/hsd_nonlin.sv
module hsd_nonlin
  import hsd_pkg::*;
(
  input  logic               rmd,
  input  logic [ROUND_W-1:0] rnd,
  input  word_t              x,
  input  word_t              y,
  input  word_t              z,
  output word_t              f
);
  word_t cand [NUM_FN];
  fn_e   sel;

  for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
    assign cand[g] = nl_eval(fn_e'(3'(g)), x, y, z);
  end

  assign sel = fn_pick(rmd, rnd);
  assign f   = cand[int'(sel)];
endmodule

// File: rtl/hsd_step_alu.sv
module hsd_step_alu
  import hsd_pkg::*;
(
  input  logic               rmd,
  input  logic [ROUND_W-1:0] rnd,
  input  vec_t               cur,
  input  word_t              msg,
  input  word_t              kon,
  input  logic [ROT_W-1:0]   rot,
  output vec_t               nxt
);
  word_t            fval;
  word_t            sum;
  word_t            spun;
  logic [ROT_W-1:0] eff_rot;

  hsd_nonlin u_nl (
    .rmd (rmd),
    .rnd (rnd),
    .x   (cur[SLOT_B]),
    .y   (cur[SLOT_C]),
    .z   (cur[SLOT_D]),
    .f   (fval)
  );

  // RIPEMD shifts never exceed 15: the top rotate bit is dropped
  assign eff_rot = rmd ? {1'b0, rot[ROT_W-2:0]} : rot;
  assign sum     = cur[SLOT_A] + fval + msg + kon;
  assign spun    = rotl(sum, int'(eff_rot));

  always_comb begin
    if (!rmd) begin
      nxt[SLOT_A] = cur[SLOT_D];
      nxt[SLOT_B] = cur[SLOT_B] + spun;
      nxt[SLOT_C] = cur[SLOT_B];
      nxt[SLOT_D] = cur[SLOT_C];
      nxt[SLOT_E] = cur[SLOT_E];
    end else begin
      nxt[SLOT_A] = cur[SLOT_E];
      nxt[SLOT_B] = spun + cur[SLOT_E];
      nxt[SLOT_C] = cur[SLOT_B];
      nxt[SLOT_D] = rotl(cur[SLOT_C], FIXED_ROT);
      nxt[SLOT_E] = cur[SLOT_D];
    end
  end
endmodule

// File: rtl/hsd_chain.sv
module hsd_chain
  import hsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rmd,
  input  logic load_iv,
  input  logic fold,
  input  vec_t work,
  input  vec_t saved,
  output vec_t iv_vec,
  output vec_t fold_vec,
  output vec_t chain
);
  vec_t chain_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_iv
    assign iv_vec[w] = iv_word(rmd, w);
  end

  always_comb begin
    if (!rmd) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        fold_vec[w] = (w == SLOT_E) ? chain_q[w] : chain_q[w] + work[w];
      end
    end else begin
      fold_vec[SLOT_A] = chain_q[SLOT_B] + saved[SLOT_C] + work[SLOT_D];
      fold_vec[SLOT_B] = chain_q[SLOT_C] + saved[SLOT_D] + work[SLOT_E];
      fold_vec[SLOT_C] = chain_q[SLOT_D] + saved[SLOT_E] + work[SLOT_A];
      fold_vec[SLOT_D] = chain_q[SLOT_E] + saved[SLOT_A] + work[SLOT_B];
      fold_vec[SLOT_E] = chain_q[SLOT_A] + saved[SLOT_B] + work[SLOT_C];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load_iv) chain_q <= iv_vec;
    else if (fold)         chain_q <= fold_vec;
  end

  assign chain = chain_q;
endmodule

// File: rtl/hash_step_core.sv
module hash_step_core
  import hsd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_i,
  input  logic                init_i,
  input  logic                step_i,
  input  logic                swap_i,
  input  logic                final_i,
  input  logic [ROUND_W-1:0]  round_i,
  input  logic [WORD_W-1:0]   msg_i,
  input  logic [WORD_W-1:0]   const_i,
  input  logic [ROT_W-1:0]    rot_i,
  output logic [STATE_W-1:0]  state_o,
  output logic [STATE_W-1:0]  chain_o
);
  // strobe decode with fixed priority: init > final > swap > step
  logic init_fire;
  logic final_fire;
  logic swap_fire;
  logic step_fire;

  assign init_fire  = init_i;
  assign final_fire = final_i && !init_i;
  assign swap_fire  = swap_i  && !init_i && !final_i;
  assign step_fire  = step_i  && !init_i && !final_i && !swap_i;

  vec_t work_q;
  vec_t save_q;
  vec_t step_nxt;
  vec_t iv_vec;
  vec_t fold_vec;
  vec_t chain_vec;

  hsd_step_alu u_alu (
    .rmd (mode_i),
    .rnd (round_i),
    .cur (work_q),
    .msg (msg_i),
    .kon (const_i),
    .rot (rot_i),
    .nxt (step_nxt)
  );

  hsd_chain u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .rmd      (mode_i),
    .load_iv  (init_fire),
    .fold     (final_fire),
    .work     (work_q),
    .saved    (save_q),
    .iv_vec   (iv_vec),
    .fold_vec (fold_vec),
    .chain    (chain_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q <= iv_vec;
      save_q <= '0;
    end else if (init_fire) begin
      work_q <= iv_vec;
    end else if (final_fire) begin
      work_q <= fold_vec;
    end else if (swap_fire) begin
      save_q <= work_q;
      work_q <= chain_vec;
    end else if (step_fire) begin
      work_q <= step_nxt;
    end
  end

  assign state_o = work_q;
  assign chain_o = chain_vec;
endmodule

// File: rtl/hsd_checker.sv
module hsd_checker
  import hsd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mode_i,
  input logic               init_i,
  input logic               step_i,
  input logic               swap_i,
  input logic               final_i,
  input logic [STATE_W-1:0] state_o,
  input logic [STATE_W-1:0] chain_o,
  input logic               step_fire,
  input logic               swap_fire
);
  logic idle;
  assign idle = !init_i && !step_i && !swap_i && !final_i;

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (chain_o[159:128] == 32'h67452301) && (state_o == chain_o) &&
               (chain_o[31:0] == ($past(mode_i) ? 32'hc3d2e1f0 : 32'h0)));  // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(state_o) && $stable(chain_o));  // R2

  AST_MD5_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !mode_i) |=> (state_o[159:128] == $past(state_o[63:32])) &&
                               (state_o[95:64]  == $past(state_o[127:96])) &&
                               (state_o[63:32]  == $past(state_o[95:64])) &&
                               $stable(state_o[31:0]));  // R3

  AST_RMD_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && mode_i) |=> (state_o[159:128] == $past(state_o[31:0])) &&
                              (state_o[95:64]  == $past(state_o[127:96])) &&
                              (state_o[63:32]  == rotl($past(state_o[95:64]), FIXED_ROT)) &&
                              (state_o[31:0]   == $past(state_o[63:32])));  // R5

  AST_STEP_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> $stable(chain_o));  // R3

  AST_SWAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> (state_o == $past(chain_o)) && $stable(chain_o));  // R8

  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && (step_i || swap_i || final_i)) |=> (state_o == chain_o));  // R11
endmodule

bind hash_step_core hsd_checker u_chk (.*);

// File: tb/hash_step_core_bench.sv
module hash_step_core_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_i = 1'b0;
  logic         init_i = 1'b0;
  logic         step_i = 1'b0;
  logic         swap_i = 1'b0;
  logic         final_i = 1'b0;
  logic [2:0]   round_i = 3'd0;
  logic [31:0]  msg_i = 32'h0;
  logic [31:0]  const_i = 32'h0;
  logic [4:0]   rot_i = 5'd0;
  logic [159:0] state_o;
  logic [159:0] chain_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] seed = 32'h2545f491;

  // model: index 0 = A ... 4 = E
  logic [31:0] m_st [5];
  logic [31:0] m_ch [5];
  logic [31:0] m_sv [5];

  always #10 clk = ~clk;

  hash_step_core u_hash_step_core (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .init_i(init_i), .step_i(step_i),
    .swap_i(swap_i), .final_i(final_i), .round_i(round_i), .msg_i(msg_i),
    .const_i(const_i), .rot_i(rot_i), .state_o(state_o), .chain_o(chain_o)
  );

  function automatic logic [31:0] rnd32(inout logic [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return s;
  endfunction

  function automatic logic [31:0] b_rol(logic [31:0] x, int s);
    logic [63:0] d;
    d = {x, x} << s;
    return d[63:32];
  endfunction

  function automatic logic [31:0] b_fn(logic rmd, logic [2:0] r,
                                        logic [31:0] b, logic [31:0] c, logic [31:0] d);
    if (!rmd) begin
      case (r[1:0])
        2'd0: return (b & c) | (~b & d);
        2'd1: return (b & d) | (c & ~d);
        2'd2: return b ^ c ^ d;
        default: return c ^ (b | ~d);
      endcase
    end
    case (r)
      3'd0: return b ^ c ^ d;
      3'd1: return (b & c) | (~b & d);
      3'd2: return (b | ~c) ^ d;
      3'd3: return (b & d) | (c & ~d);
      3'd4: return b ^ (c | ~d);
      default: return b ^ c ^ d;
    endcase
  endfunction

  task automatic model_iv(input logic rmd);
    m_ch[0] = 32'h67452301; m_ch[1] = 32'hefcdab89;
    m_ch[2] = 32'h98badcfe; m_ch[3] = 32'h10325476;
    m_ch[4] = rmd ? 32'hc3d2e1f0 : 32'h0;
    for (int i = 0; i < 5; i++) m_st[i] = m_ch[i];
  endtask

  task automatic check(input string tag, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_both(input string tag);
    check({tag, " state"}, state_o, {m_st[0], m_st[1], m_st[2], m_st[3], m_st[4]});
    check({tag, " chain"}, chain_o, {m_ch[0], m_ch[1], m_ch[2], m_ch[3], m_ch[4]});
  endtask

  // one clock: drive now (just after a falling edge), model with the
  // priority of R11, then return at the next falling edge
  task automatic cyc(input logic i_init, input logic i_step, input logic i_swap,
                     input logic i_final, input logic md, input logic [2:0] r,
                     input logic [31:0] x, input logic [31:0] k, input logic [4:0] s);
    logic [31:0] t;
    logic [31:0] nw [5];
    mode_i = md; init_i = i_init; step_i = i_step; swap_i = i_swap; final_i = i_final;
    round_i = r; msg_i = x; const_i = k; rot_i = s;
    if (i_init) begin
      model_iv(md);
    end else if (i_final) begin
      for (int i = 0; i < 5; i++) begin
        if (!md) nw[i] = (i == 4) ? m_ch[i] : m_ch[i] + m_st[i];
        else     nw[i] = m_ch[(i+1)%5] + m_sv[(i+2)%5] + m_st[(i+3)%5];
      end
      for (int i = 0; i < 5; i++) begin m_ch[i] = nw[i]; m_st[i] = nw[i]; end
    end else if (i_swap) begin
      for (int i = 0; i < 5; i++) begin m_sv[i] = m_st[i]; m_st[i] = m_ch[i]; end
    end else if (i_step) begin
      if (!md) begin
        t = b_rol(m_st[0] + b_fn(0, r, m_st[1], m_st[2], m_st[3]) + x + k, int'(s));
        nw[0] = m_st[3]; nw[1] = m_st[1] + t; nw[2] = m_st[1]; nw[3] = m_st[2]; nw[4] = m_st[4];
      end else begin
        t = b_rol(m_st[0] + b_fn(1, r, m_st[1], m_st[2], m_st[3]) + x + k, int'(s & 5'd15)) + m_st[4];
        nw[0] = m_st[4]; nw[1] = t; nw[2] = m_st[1]; nw[3] = b_rol(m_st[2], 10); nw[4] = m_st[3];
      end
      for (int i = 0; i < 5; i++) m_st[i] = nw[i];
    end
    @(posedge clk);
    @(negedge clk);
    init_i = 1'b0; step_i = 1'b0; swap_i = 1'b0; final_i = 1'b0;
  endtask

  task automatic do_step(input logic md, input logic [2:0] r, input logic [4:0] s, input string tag);
    logic [31:0] x;
    logic [31:0] k;
    x = rnd32(seed);
    k = rnd32(seed);
    cyc(0, 1, 0, 0, md, r, x, k, s);
    check_both(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mode_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_iv(0);
    check_both("R1 reset md5");

    // R2: data inputs wiggle, no strobe
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, i[0], 3'(i), rnd32(seed), rnd32(seed), 5'(i * 7));
      check_both("R2 idle");
    end

    // MD5 block: every round code with every rotate amount (R3 R4 R7)
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    check_both("R1 init md5");
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 32; s++)
        do_step(0, 3'(r), 5'(s), "R3 R4 R7 md5 step");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    check_both("R9 md5 fold");
    for (int s = 0; s < 16; s++) do_step(0, 3'(s % 4), 5'(31 - s), "R3 md5 second block");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    check_both("R9 md5 fold 2");

    // RIPEMD block: left line, swap, right line with reversed codes, fold
    cyc(1, 0, 0, 0, 1, 0, 0, 0, 0);
    check_both("R1 init rmd");
    for (int r = 0; r < 5; r++)
      for (int j = 0; j < 16; j++)
        do_step(1, 3'(r), {j[0], 4'(j)}, "R5 R6 R7 rmd left");
    cyc(0, 0, 1, 0, 1, 0, 0, 0, 0);
    check_both("R8 swap");
    for (int r = 0; r < 5; r++)
      for (int j = 0; j < 16; j++)
        do_step(1, 3'(4 - r), {~j[0], 4'(15 - j)}, "R5 R6 R7 rmd right");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, 0);
    check_both("R10 rmd fold");

    // R11 priority corners
    for (int j = 0; j < 3; j++) do_step(1, 3'(j), 5'(j + 5), "R11 prep");
    cyc(1, 1, 1, 1, 0, 2, 32'h1234, 32'h5678, 5'd9);
    check_both("R11 init beats all");
    do_step(0, 1, 5'd3, "R11 prep md5");
    cyc(0, 1, 1, 0, 0, 1, 32'hdead, 32'hbeef, 5'd4);
    check_both("R11 swap beats step");
    do_step(0, 2, 5'd17, "R11 prep md5 b");
    cyc(0, 1, 1, 1, 0, 1, 32'h1, 32'h2, 5'd4);
    check_both("R11 final beats swap");

    // reset again in RIPEMD mode (R1)
    rst_n = 1'b0; mode_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_iv(1);
    check_both("R1 reset rmd");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule